// File: doc/BRIEF.md
# Flush-to-Zero Denormal Exception Stage

This block sits around a floating-point operation and applies a nonstandard flush-to-zero mode. When the mode bit is set, it replaces a subnormal source operand with a zero of the same sign before the arithmetic sees it. It also turns a result that would be subnormal before rounding into a signed zero. The current-exception flags and any trap request are derived from the same decision, so the arithmetic unit never has to deal with subnormal values. When the mode bit is clear, the data passes through untouched. A subnormal value then asks for an unfinished-operation trap, which lets software complete the operation.

Operands and the unrounded result arrive as IEEE-style words (sign, biased exponent, fraction), together with the opcode and the divide-by-zero and invalid detections from the datapath. The adjusted words, flags and trap information leave through one registered stage with a valid/ready handshake. A trap request stays raised until it is acknowledged, and no new operation is accepted while it is pending.

Top module: `ftz_handler`

## Requirements
- R1: After reset, `out_valid` and `trap_req` are 0 and `in_ready` is 1.
- R2: With `mode_ns`=1 and a two-operand opcode (add 0, sub 1, mul 2, div 3, and codes 5 to 7), if either operand is subnormal and neither operand is zero, infinity or NaN, each subnormal operand leaves as a zero carrying its own sign, and the other operand leaves unchanged. Inexact (`cexc` bit 0) is set.
- R3: With `mode_ns`=1, a subnormal operand is left unchanged and raises no inexact when the other operand of a two-operand opcode is zero, infinity or NaN.
- R4: For square root (opcode 4), only operand A is examined. A subnormal A is flushed with inexact when `mode_ns`=1, and operand B leaves unchanged and has no effect on flags or traps.
- R5: The inexact caused by an operand flush is withheld when the opcode is divide and `dz_det` or `nv_det` is set, or when the opcode is square root and `nv_det` is set. Opcodes other than divide and square root keep it.
- R6: With `mode_ns`=1 and `res_den`=1, the result leaves as a zero with the result's sign. Underflow (`cexc` bit 2) is reported if `trap_en` bit 2 is set; otherwise inexact (bit 0) is reported.
- R7: With `mode_ns`=0, operands and result pass unchanged and no flush-related flag is raised. A subnormal operand that the opcode reads, or `res_den`=1, requests a trap with type 0x22 and fault type 2. With `mode_ns`=1, fault type 2 is never produced.
- R8: `cexc` layout is invalid bit 4, overflow bit 3 (always 0), underflow bit 2, divide-by-zero bit 1, inexact bit 0. Bits 4 and 1 copy `nv_det` and `dz_det`. If no unfinished trap applies and any `cexc` bit meets a set `trap_en` bit, a trap is requested with type 0x21 and fault type 1. With no trap, type and fault type are 0.
- R9: A raised `trap_req` stays high until `trap_ack` is sampled high, and `in_ready` is 0 while it is high.
- R10: An operation is taken when `in_valid` and `in_ready` are both high. Its results appear on the outputs after that clock edge and stay stable while `out_valid`=1 and `out_ready`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be taken |
| mode_ns | input | 1 | Flush-to-zero mode enable |
| trap_en | input | 5 | Trap-enable mask, same bit layout as `cexc` |
| opcode | input | 3 | Operation code |
| op_a | input | WIDTH | Operand A word |
| op_b | input | WIDTH | Operand B word |
| res_in | input | WIDTH | Unrounded result word from the datapath |
| res_den | input | 1 | Unrounded result is subnormal |
| dz_det | input | 1 | Datapath detected divide by zero |
| nv_det | input | 1 | Datapath detected invalid operation |
| out_valid | output | 1 | Output fields hold a completed operation |
| out_ready | input | 1 | Consumer takes the output |
| out_a | output | WIDTH | Adjusted operand A |
| out_b | output | WIDTH | Adjusted operand B |
| out_res | output | WIDTH | Adjusted result |
| cexc | output | 5 | Current-exception flags |
| trap_req | output | 1 | Trap requested, held until acknowledged |
| trap_ack | input | 1 | Trap acknowledge |
| trap_type | output | 8 | Trap type code |
| fault_type | output | 3 | Fault type code |

## Verification
The assertions assume that `res_den` and the two detection inputs describe the same operation as the operand words, and that `trap_ack` is only raised while a trap is pending. The bench drives these inputs together with the operands in one task call. It raises `trap_ack` only after it has seen `trap_req` high. Operand words are chosen from a fixed set of zero, subnormal, normal, infinity and NaN encodings, so every class combination the requirements name is reached on purpose.

// File: rtl/ftz_pkg.sv
package ftz_pkg;

   typedef enum logic [2:0] {
      FOP_ADD  = 3'd0,
      FOP_SUB  = 3'd1,
      FOP_MUL  = 3'd2,
      FOP_DIV  = 3'd3,
      FOP_SQRT = 3'd4
   } fop_e;

   localparam int XB_NX = 0;
   localparam int XB_DZ = 1;
   localparam int XB_UF = 2;
   localparam int XB_OF = 3;
   localparam int XB_NV = 4;
   localparam int XC_W  = 5;

   localparam logic [7:0] TT_NONE  = 8'h00;
   localparam logic [7:0] TT_IEEE  = 8'h21;
   localparam logic [7:0] TT_UNFIN = 8'h22;

   localparam logic [2:0] FT_NONE  = 3'd0;
   localparam logic [2:0] FT_IEEE  = 3'd1;
   localparam logic [2:0] FT_UNFIN = 3'd2;

   typedef struct packed {
      logic zero;
      logic den;
      logic inf;
      logic nan;
   } fcls_t;

endpackage

// File: rtl/ftz_classify.sv
module ftz_classify
   import ftz_pkg::*;
#(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23,
   localparam int W     = 1 + EXP_W + FRAC_W
) (
   input  logic [W-1:0] word_i,
   output fcls_t        cls_o
);

   logic [EXP_W-1:0]  exp_f;
   logic [FRAC_W-1:0] frac_f;
   logic              exp_lo;
   logic              exp_hi;
   logic              frac_nz;

   assign exp_f   = word_i[W-2 -: EXP_W];
   assign frac_f  = word_i[FRAC_W-1:0];
   assign exp_lo  = (exp_f == '0);
   assign exp_hi  = (exp_f == '1);
   assign frac_nz = (frac_f != '0);

   always_comb begin
      cls_o.zero = exp_lo & ~frac_nz;
      cls_o.den  = exp_lo &  frac_nz;
      cls_o.inf  = exp_hi & ~frac_nz;
      cls_o.nan  = exp_hi &  frac_nz;
   end

endmodule

// File: rtl/ftz_decide.sv
module ftz_decide
   import ftz_pkg::*;
(
   input  logic            mode_ns,
   input  logic [XC_W-1:0] trap_en,
   input  logic [2:0]      opcode,
   input  fcls_t           cls_a,
   input  fcls_t           cls_b,
   input  logic            res_den,
   input  logic            dz_det,
   input  logic            nv_det,
   output logic            flush_a,
   output logic            flush_b,
   output logic            flush_res,
   output logic [XC_W-1:0] cexc,
   output logic            trap,
   output logic [7:0]      tt,
   output logic [2:0]      ftt
);

   logic is_sqrt;
   logic is_div;
   logic a_finite_nz;
   logic b_finite_nz;
   logic in_flush;
   logic quiet_nx;
   logic unfin;
   logic ieee;

   assign is_sqrt     = (opcode == FOP_SQRT);
   assign is_div      = (opcode == FOP_DIV);
   assign a_finite_nz = ~(cls_a.zero | cls_a.inf | cls_a.nan);
   assign b_finite_nz = ~(cls_b.zero | cls_b.inf | cls_b.nan);

   always_comb begin
      if (is_sqrt) begin
         flush_a = mode_ns & cls_a.den;
         flush_b = 1'b0;
      end else begin
         flush_a = mode_ns & cls_a.den & a_finite_nz & b_finite_nz;
         flush_b = mode_ns & cls_b.den & a_finite_nz & b_finite_nz;
      end
   end

   assign in_flush  = flush_a | flush_b;
   assign quiet_nx  = (is_div & (dz_det | nv_det)) | (is_sqrt & nv_det);
   assign flush_res = mode_ns & res_den;

   always_comb begin
      cexc        = '0;
      cexc[XB_NV] = nv_det;
      cexc[XB_DZ] = dz_det;
      cexc[XB_UF] = flush_res & trap_en[XB_UF];
      cexc[XB_NX] = (in_flush & ~quiet_nx) | (flush_res & ~trap_en[XB_UF]);
   end

   assign unfin = ~mode_ns & (cls_a.den | (~is_sqrt & cls_b.den) | res_den);
   assign ieee  = |(cexc & trap_en);
   assign trap  = unfin | ieee;

   always_comb begin
      if (unfin) begin
         tt  = TT_UNFIN;
         ftt = FT_UNFIN;
      end else if (ieee) begin
         tt  = TT_IEEE;
         ftt = FT_IEEE;
      end else begin
         tt  = TT_NONE;
         ftt = FT_NONE;
      end
   end

endmodule

// File: rtl/ftz_handler.sv
module ftz_handler
   import ftz_pkg::*;
#(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23,
   localparam int W     = 1 + EXP_W + FRAC_W,
   localparam int N_SRC = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            in_valid,
   output logic            in_ready,
   input  logic            mode_ns,
   input  logic [XC_W-1:0] trap_en,
   input  logic [2:0]      opcode,
   input  logic [W-1:0]    op_a,
   input  logic [W-1:0]    op_b,
   input  logic [W-1:0]    res_in,
   input  logic            res_den,
   input  logic            dz_det,
   input  logic            nv_det,
   output logic            out_valid,
   input  logic            out_ready,
   output logic [W-1:0]    out_a,
   output logic [W-1:0]    out_b,
   output logic [W-1:0]    out_res,
   output logic [XC_W-1:0] cexc,
   output logic            trap_req,
   input  logic            trap_ack,
   output logic [7:0]      trap_type,
   output logic [2:0]      fault_type
);

   if (EXP_W < 2) begin : g_bad_exp
      $error("ftz_handler: EXP_W must be at least 2");
   end
   if (FRAC_W < 1) begin : g_bad_frac
      $error("ftz_handler: FRAC_W must be at least 1");
   end

   logic [N_SRC-1:0][W-1:0] src_w;
   fcls_t [N_SRC-1:0]       src_c;
   logic [N_SRC-1:0]        src_flush;
   logic [N_SRC-1:0][W-1:0] src_adj;

   assign src_w[0] = op_a;
   assign src_w[1] = op_b;

   for (genvar g = 0; g < N_SRC; g++) begin : g_src
      ftz_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) i_cls (
         .word_i (src_w[g]),
         .cls_o  (src_c[g])
      );
      assign src_adj[g] = src_flush[g] ? {src_w[g][W-1], {(W-1){1'b0}}} : src_w[g];
   end

   logic            flush_res;
   logic [XC_W-1:0] cexc_d;
   logic            trap_d;
   logic [7:0]      tt_d;
   logic [2:0]      ftt_d;
   logic [W-1:0]    res_adj;

   ftz_decide i_decide (
      .mode_ns   (mode_ns),
      .trap_en   (trap_en),
      .opcode    (opcode),
      .cls_a     (src_c[0]),
      .cls_b     (src_c[1]),
      .res_den   (res_den),
      .dz_det    (dz_det),
      .nv_det    (nv_det),
      .flush_a   (src_flush[0]),
      .flush_b   (src_flush[1]),
      .flush_res (flush_res),
      .cexc      (cexc_d),
      .trap      (trap_d),
      .tt        (tt_d),
      .ftt       (ftt_d)
   );

   assign res_adj = flush_res ? {res_in[W-1], {(W-1){1'b0}}} : res_in;

   logic in_fire;
   assign in_ready = (~out_valid | out_ready) & ~trap_req;
   assign in_fire  = in_valid & in_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         out_a      <= '0;
         out_b      <= '0;
         out_res    <= '0;
         cexc       <= '0;
         trap_type  <= TT_NONE;
         fault_type <= FT_NONE;
      end else if (in_fire) begin
         out_valid  <= 1'b1;
         out_a      <= src_adj[0];
         out_b      <= src_adj[1];
         out_res    <= res_adj;
         cexc       <= cexc_d;
         trap_type  <= tt_d;
         fault_type <= ftt_d;
      end else if (out_ready) begin
         out_valid  <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          trap_req <= 1'b0;
      else if (in_fire)    trap_req <= trap_d;
      else if (trap_ack)   trap_req <= 1'b0;
   end

   // R9: a pending trap is held until acknowledged
   p_trap_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_req && !trap_ack) |=> trap_req);

   // R9: nothing is taken while a trap is pending
   p_trap_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
      trap_req |-> !in_ready);

   // R10: a stalled output keeps its contents
   p_out_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready && !trap_ack) |=> (out_valid && $stable(out_res) && $stable(cexc)));

   // R7: flush mode never yields the unfinished fault type
   p_ns_no_unfin_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_fire && mode_ns) |=> (fault_type != FT_UNFIN));

   // R6: flush mode never emits a subnormal result
   p_ns_res_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_fire && mode_ns && res_den) |=> (out_res[W-2:0] == '0));

   // R8: overflow is never reported
   p_no_of_r8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !cexc[XB_OF]);

endmodule

// File: tb/test_ftz_handler.sv
module test_ftz_handler;

   localparam int W = 32;

   localparam logic [W-1:0] P_ONE  = 32'h3F80_0000;
   localparam logic [W-1:0] N_TWO  = 32'hC000_0000;
   localparam logic [W-1:0] P_DEN  = 32'h0000_0001;
   localparam logic [W-1:0] N_DEN  = 32'h8040_0000;
   localparam logic [W-1:0] P_ZERO = 32'h0000_0000;
   localparam logic [W-1:0] N_ZERO = 32'h8000_0000;
   localparam logic [W-1:0] P_INF  = 32'h7F80_0000;
   localparam logic [W-1:0] Q_NAN  = 32'h7FC0_0000;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic         in_ready;
   logic         mode_ns = 1'b0;
   logic [4:0]   trap_en = '0;
   logic [2:0]   opcode = '0;
   logic [W-1:0] op_a = '0;
   logic [W-1:0] op_b = '0;
   logic [W-1:0] res_in = '0;
   logic         res_den = 1'b0;
   logic         dz_det = 1'b0;
   logic         nv_det = 1'b0;
   logic         out_valid;
   logic         out_ready = 1'b1;
   logic [W-1:0] out_a;
   logic [W-1:0] out_b;
   logic [W-1:0] out_res;
   logic [4:0]   cexc;
   logic         trap_req;
   logic         trap_ack = 1'b0;
   logic [7:0]   trap_type;
   logic [2:0]   fault_type;

   int n_vec  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   ftz_handler #(.EXP_W(8), .FRAC_W(23)) i_ftz_handler (
      .clk, .rst_n, .in_valid, .in_ready, .mode_ns, .trap_en, .opcode,
      .op_a, .op_b, .res_in, .res_den, .dz_det, .nv_det,
      .out_valid, .out_ready, .out_a, .out_b, .out_res, .cexc,
      .trap_req, .trap_ack, .trap_type, .fault_type
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic apply(input logic ns, input logic [4:0] en, input logic [2:0] op,
                        input logic [W-1:0] a, input logic [W-1:0] b,
                        input logic [W-1:0] r, input logic rd,
                        input logic dz, input logic nv);
      @(negedge clk);
      mode_ns = ns; trap_en = en; opcode = op; op_a = a; op_b = b;
      res_in = r; res_den = rd; dz_det = dz; nv_det = nv; in_valid = 1'b1;
      while (!in_ready) @(negedge clk);
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic ack_trap();
      trap_ack = 1'b1;
      @(negedge clk);
      trap_ack = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 out_valid", {31'd0, out_valid}, 32'd0);
      chk("R1 trap_req", {31'd0, trap_req}, 32'd0);
      chk("R1 in_ready", {31'd0, in_ready}, 32'd1);
   endtask

   task automatic t_operand_flush();
      apply(1, 5'h00, 3'd0, N_DEN, P_ONE, P_ONE, 0, 0, 0);
      chk("R2 add a", out_a, N_ZERO);
      chk("R2 add b", out_b, P_ONE);
      chk("R2 add cexc", {27'd0, cexc}, 32'h01);
      chk("R2 add trap", {31'd0, trap_req}, 32'd0);
      chk("R10 out_valid", {31'd0, out_valid}, 32'd1);
      apply(1, 5'h00, 3'd2, P_DEN, N_DEN, P_ZERO, 0, 0, 0);
      chk("R2 mul a", out_a, P_ZERO);
      chk("R2 mul b", out_b, N_ZERO);
      chk("R2 mul cexc", {27'd0, cexc}, 32'h01);
      apply(1, 5'h00, 3'd6, N_TWO, P_DEN, P_ONE, 0, 0, 0);
      chk("R2 code6 b", out_b, P_ZERO);
      chk("R2 code6 a", out_a, N_TWO);
   endtask

   task automatic t_special_partner();
      apply(1, 5'h00, 3'd0, P_DEN, P_ZERO, P_DEN, 0, 0, 0);
      chk("R3 zero partner a", out_a, P_DEN);
      chk("R3 zero partner cexc", {27'd0, cexc}, 32'h00);
      apply(1, 5'h00, 3'd2, P_INF, N_DEN, P_INF, 0, 0, 0);
      chk("R3 inf partner b", out_b, N_DEN);
      chk("R3 inf partner cexc", {27'd0, cexc}, 32'h00);
      apply(1, 5'h00, 3'd1, N_DEN, Q_NAN, Q_NAN, 0, 0, 0);
      chk("R3 nan partner a", out_a, N_DEN);
   endtask

   task automatic t_sqrt();
      apply(1, 5'h00, 3'd4, P_DEN, P_ZERO, P_ZERO, 0, 0, 0);
      chk("R4 sqrt a", out_a, P_ZERO);
      chk("R4 sqrt cexc", {27'd0, cexc}, 32'h01);
      apply(1, 5'h01, 3'd4, P_ONE, N_DEN, P_ONE, 0, 0, 0);
      chk("R4 sqrt b kept", out_b, N_DEN);
      chk("R4 sqrt b no flag", {27'd0, cexc}, 32'h00);
      chk("R4 sqrt b no trap", {31'd0, trap_req}, 32'd0);
   endtask

   task automatic t_suppress();
      apply(1, 5'h00, 3'd3, P_ONE, P_DEN, P_INF, 0, 1, 0);
      chk("R5 div dz b", out_b, P_ZERO);
      chk("R5 div dz cexc", {27'd0, cexc}, 32'h02);
      apply(1, 5'h00, 3'd3, P_DEN, P_ONE, Q_NAN, 0, 0, 1);
      chk("R5 div nv cexc", {27'd0, cexc}, 32'h10);
      apply(1, 5'h00, 3'd4, N_DEN, P_ZERO, Q_NAN, 0, 0, 1);
      chk("R5 sqrt nv cexc", {27'd0, cexc}, 32'h10);
      apply(1, 5'h00, 3'd2, P_DEN, P_ONE, P_ONE, 0, 1, 0);
      chk("R5 mul keeps nx", {27'd0, cexc}, 32'h03);
   endtask

   task automatic t_result_flush();
      apply(1, 5'h00, 3'd2, P_ONE, P_ONE, 32'h8000_0005, 1, 0, 0);
      chk("R6 res zero", out_res, N_ZERO);
      chk("R6 res nx", {27'd0, cexc}, 32'h01);
      chk("R6 no trap", {31'd0, trap_req}, 32'd0);
      apply(1, 5'h04, 3'd2, P_ONE, P_ONE, 32'h0000_0005, 1, 0, 0);
      chk("R6 res zero uf", out_res, P_ZERO);
      chk("R6 res uf", {27'd0, cexc}, 32'h04);
      chk("R8 uf trap", {31'd0, trap_req}, 32'd1);
      chk("R8 uf tt", {24'd0, trap_type}, 32'h21);
      chk("R8 uf ftt", {29'd0, fault_type}, 32'd1);
      ack_trap();
   endtask

   task automatic t_mode_clear();
      apply(0, 5'h00, 3'd0, P_ONE, P_ONE, P_ONE, 0, 0, 0);
      chk("R7 plain res", out_res, P_ONE);
      chk("R7 plain cexc", {27'd0, cexc}, 32'h00);
      chk("R7 plain no trap", {31'd0, trap_req}, 32'd0);
      apply(0, 5'h01, 3'd0, N_DEN, P_ONE, 32'h8000_0007, 1, 0, 0);
      chk("R7 a kept", out_a, N_DEN);
      chk("R7 res kept", out_res, 32'h8000_0007);
      chk("R7 cexc", {27'd0, cexc}, 32'h00);
      chk("R7 trap", {31'd0, trap_req}, 32'd1);
      chk("R7 tt", {24'd0, trap_type}, 32'h22);
      chk("R7 ftt", {29'd0, fault_type}, 32'd2);
      ack_trap();
      apply(0, 5'h00, 3'd4, P_ONE, P_DEN, P_ONE, 0, 0, 0);
      chk("R7 sqrt b unread", {31'd0, trap_req}, 32'd0);
   endtask

   task automatic t_trap_hold();
      apply(1, 5'h01, 3'd0, P_ONE, N_DEN, P_ONE, 0, 0, 0);
      chk("R8 nx trap", {31'd0, trap_req}, 32'd1);
      chk("R8 nx tt", {24'd0, trap_type}, 32'h21);
      chk("R8 nx ftt", {29'd0, fault_type}, 32'd1);
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         chk("R9 held", {31'd0, trap_req}, 32'd1);
         chk("R9 stalled", {31'd0, in_ready}, 32'd0);
      end
      ack_trap();
      chk("R9 cleared", {31'd0, trap_req}, 32'd0);
      chk("R9 ready again", {31'd0, in_ready}, 32'd1);
      apply(1, 5'h02, 3'd3, P_ONE, P_ONE, P_INF, 0, 1, 0);
      chk("R8 dz trap tt", {24'd0, trap_type}, 32'h21);
      ack_trap();
   endtask

   task automatic t_backpressure();
      logic [W-1:0] held;
      @(negedge clk);
      out_ready = 1'b0;
      apply(1, 5'h00, 3'd0, P_ONE, P_ONE, N_TWO, 0, 0, 0);
      held = out_res;
      chk("R10 captured", held, N_TWO);
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         chk("R10 valid held", {31'd0, out_valid}, 32'd1);
         chk("R10 res stable", out_res, held);
         chk("R10 not ready", {31'd0, in_ready}, 32'd0);
      end
      out_ready = 1'b1;
      @(negedge clk);
      chk("R10 drained", {31'd0, out_valid}, 32'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_operand_flush();
      t_special_partner();
      t_sqrt();
      t_suppress();
      t_result_flush();
      t_mode_clear();
      t_trap_hold();
      t_backpressure();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_vec++;
         n_fail++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
         $finish;
      end
   end

endmodule